// File: doc/BRIEF.md
# Fifth-Order Sinc Decimator

This block turns the one-bit stream of a delta-sigma modulator into signed 24-bit conversion words. The system clock is divided by six to form a sample strobe. On each strobe the modulator bit is taken as +1 or -1 and fed into a chain of five running-sum stages. After every 64 samples, five first-difference stages at the reduced rate form the output of a fifth-order moving-average (sinc) filter. The full-precision sum is scaled to 24 bits and clipped at the two ends of the range. A new word therefore appears once every 384 system clocks.

A synchronous restart input discards all filter history. A host drives it after switching the analog input, for example. The restart zeroes every running sum, difference register and counter. A settled flag reports whether the current word is built entirely from samples taken after the last restart or reset. The filter spans five conversion windows, so the flag stays low for the first four words and rises with the fifth.

Top module: `sinc5_decimator`

## Requirements
- R1: Each word is the fifth-order cascade of 64-sample moving sums of the mapped bit stream. Once settled, a stream whose 64-sample window holds as many ones as zeros gives 0x000000.
- R2: `mod_bit` is sampled once every 6 system clocks, on the sixth clock after a restart or reset and every sixth clock after that. The value it holds on the other five clocks has no effect on any result.
- R3: `result_valid` is one clock wide. It is high exactly 384 clocks after the clock edge that applies a restart, and then again every 384 clocks.
- R4: `result` is two's complement: 0x7FFFFF is the positive end, 0x000000 is zero and 0x800000 is the negative end. A settled all-zeros stream gives 0x800000.
- R5: A full-precision value above the positive end is clipped. A settled all-ones stream gives 0x7FFFFF.
- R6: `settled` is low with the first four words after a restart or reset. It rises together with `result_valid` for the fifth word and stays high until the next restart or reset.
- R7: While `restart` is high, the next edge clears `settled` and all filter state. No word is issued until 384 clocks later, even if a conversion was in progress.
- R8: While `rst_n` is low, a clock edge drives `result` to 0x000000 and `result_valid` and `settled` to 0.
- R9: A one maps to +1 and a zero to -1 before the sums. Once settled, a stream with three ones in every four bits gives 0x400000, and one with one in every four gives 0xC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous clear of all filter state and counters |
| mod_bit | input | 1 | One-bit modulator output |
| result | output | 24 | Latest conversion word, two's complement |
| result_valid | output | 1 | One-clock strobe that marks a new word |
| settled | output | 1 | Current word is free of pre-restart history |

## Verification
The bench builds the block with its default values: clock division 6, decimation 64, order 5 and a 24-bit word. With these values the first settled word arrives after 1920 clocks, so every check on timing, flags and values runs in a few thousand cycles. Every test stream repeats with a period that divides 64, which makes each 64-sample window sum identical. Each settled word therefore has one exact expected value, including the clipped positive end and the two quarter-scale points.

// File: rtl/sinc5_pkg.sv
// Package: shared sizing helpers for the sinc5 decimator.
// Assumes decimation is a power of two, so growth per stage is a whole number of bits.
package sinc5_pkg;

    // Bits of gain growth for a cascade of 'order' moving sums of length 'decim'.
    function automatic int growth_bits(input int order, input int decim);
        return order * $clog2(decim);
    endfunction

endpackage

// File: rtl/sinc5_cadence.sv
// Module: sinc5_cadence
// Purpose: divides the system clock into the sample strobe and counts samples into
// decimation frames. frame_stb marks the sample strobe that closes a frame.
// Assumes CLK_DIV >= 2 and DECIM >= 2.
module sinc5_cadence #(
    parameter int CLK_DIV = 6,
    parameter int DECIM   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sample_stb,
    output logic frame_stb
);
    localparam int DIV_W = $clog2(CLK_DIV);
    localparam int DEC_W = $clog2(DECIM);

    logic [DIV_W-1:0] div_cnt;
    logic [DEC_W-1:0] dec_cnt;

    assign sample_stb = (div_cnt == DIV_W'(CLK_DIV - 1));
    assign frame_stb  = sample_stb && (dec_cnt == DEC_W'(DECIM - 1));

    // Clock divider: wraps after CLK_DIV clocks, restarts from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            div_cnt <= '0;
        else if (sample_stb)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // Sample counter within the current decimation frame.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            dec_cnt <= '0;
        else if (frame_stb)
            dec_cnt <= '0;
        else if (sample_stb)
            dec_cnt <= dec_cnt + 1'b1;
    end

    AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R2
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < DIV_W'(CLK_DIV)); // R2

endmodule

// File: rtl/sinc5_integ.sv
// Module: sinc5_integ
// Purpose: chain of ORDER running-sum stages, updated once per sample strobe.
// sum_next exposes the post-update value of the last stage in the same cycle, so a
// frame strobe sees the sample it closes. Wraparound is intended and harmless.
module sinc5_integ #(
    parameter int ORDER = 5,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    sample_stb,
    input  logic                    mod_bit,
    output logic signed [ACC_W-1:0] sum_next
);
    localparam logic signed [ACC_W-1:0] PLUS_ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINUS_ONE = '1;

    logic signed [ACC_W-1:0] mapped;
    logic signed [ACC_W-1:0] acc [ORDER];
    logic signed [ACC_W-1:0] nxt [ORDER];

    assign mapped = mod_bit ? PLUS_ONE : MINUS_ONE;

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign nxt[i] = acc[i] + mapped;
        end else begin : g_rest
            assign nxt[i] = acc[i] + nxt[i-1];
        end

        // Stage register: takes the new running sum on each sample strobe.
        always_ff @(posedge clk) begin
            if (!rst_n || restart)
                acc[i] <= '0;
            else if (sample_stb)
                acc[i] <= nxt[i];
        end
    end

    assign sum_next = nxt[ORDER-1];

endmodule

// File: rtl/sinc5_comb.sv
// Module: sinc5_comb
// Purpose: ORDER first-difference stages at the decimated rate (delay of one frame).
// diff_out is combinational from the input and the stored frame values.
module sinc5_comb #(
    parameter int ORDER = 5,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    frame_stb,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] diff_out
);
    logic signed [ACC_W-1:0] held [ORDER];
    logic signed [ACC_W-1:0] stage_in [ORDER];
    logic signed [ACC_W-1:0] diff [ORDER];

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_in[i] = din;
        end else begin : g_rest
            assign stage_in[i] = diff[i-1];
        end
        assign diff[i] = stage_in[i] - held[i];

        // Previous-frame store for this difference stage.
        always_ff @(posedge clk) begin
            if (!rst_n || restart)
                held[i] <= '0;
            else if (frame_stb)
                held[i] <= stage_in[i];
        end
    end

    assign diff_out = diff[ORDER-1];

endmodule

// File: rtl/sinc5_scale.sv
// Module: sinc5_scale
// Purpose: arithmetic shift of the full-precision sum down to OUT_W bits, clipping
// values beyond the signed output range. Assumes GROWTH + 1 >= OUT_W.
module sinc5_scale #(
    parameter int ACC_W  = 32,
    parameter int GROWTH = 30,
    parameter int OUT_W  = 24
) (
    input  logic signed [ACC_W-1:0] din,
    output logic        [OUT_W-1:0] dout
);
    localparam int SHIFT = GROWTH + 1 - OUT_W;
    localparam logic signed [ACC_W-1:0] TOP_V = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] BOT_V = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0] shifted;

    assign shifted = din >>> SHIFT;

    // Clip to the output range, else keep the low OUT_W bits.
    always_comb begin
        if (shifted > TOP_V)
            dout = TOP_V[OUT_W-1:0];
        else if (shifted < BOT_V)
            dout = BOT_V[OUT_W-1:0];
        else
            dout = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/sinc5_decimator.sv
// Module: sinc5_decimator (top)
// Purpose: fifth-order sinc decimator from a one-bit modulator stream to signed words,
// with restart and a settled flag after SETTLE_CONV words.
// Assumes the modulator bit is stable around the sample strobe (every CLK_DIV clocks).
module sinc5_decimator #(
    parameter int CLK_DIV     = 6,
    parameter int DECIM       = 64,
    parameter int ORDER       = 5,
    parameter int OUT_W       = 24,
    parameter int SETTLE_CONV = ORDER
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] result,
    output logic             result_valid,
    output logic             settled
);
    import sinc5_pkg::*;

    localparam int GROWTH = growth_bits(ORDER, DECIM);
    localparam int ACC_W  = GROWTH + 2;
    localparam int CNT_W  = $clog2(SETTLE_CONV + 1);

    logic                    sample_stb;
    logic                    frame_stb;
    logic signed [ACC_W-1:0] integ_sum;
    logic signed [ACC_W-1:0] comb_out;
    logic        [OUT_W-1:0] scaled;
    logic        [CNT_W-1:0] conv_cnt;

    sinc5_cadence #(.CLK_DIV(CLK_DIV), .DECIM(DECIM)) u_cadence (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .sample_stb(sample_stb), .frame_stb(frame_stb)
    );

    sinc5_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .sample_stb(sample_stb), .mod_bit(mod_bit), .sum_next(integ_sum)
    );

    sinc5_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .frame_stb(frame_stb), .din(integ_sum), .diff_out(comb_out)
    );

    sinc5_scale #(.ACC_W(ACC_W), .GROWTH(GROWTH), .OUT_W(OUT_W)) u_scale (
        .din(comb_out), .dout(scaled)
    );

    // Output word and strobe: captured at the close of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= frame_stb && !restart;
            if (frame_stb && !restart)
                result <= scaled;
        end
    end

    // Settling counter: counts words since restart, saturating at SETTLE_CONV.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            conv_cnt <= '0;
        else if (frame_stb && conv_cnt != CNT_W'(SETTLE_CONV))
            conv_cnt <= conv_cnt + 1'b1;
    end

    assign settled = (conv_cnt == CNT_W'(SETTLE_CONV));

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R3
    AST_VALID_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(frame_stb)); // R3
    AST_SETTLE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> result_valid); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!settled && !result_valid)); // R7

endmodule

// File: tb/sim_sinc5_decimator.sv
module sim_sinc5_decimator;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        mod_bit = 1'b0;
    logic [23:0] result;
    logic        result_valid;
    logic        settled;

    int n_chk = 0;
    int n_bad = 0;
    int res_cnt;
    int res_at  [0:15];
    bit res_set [0:15];
    logic [23:0] res_val [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    sinc5_decimator u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mod_bit(mod_bit),
        .result(result), .result_valid(result_valid), .settled(settled)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit pat(input int kind, input int j);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return (j % 2) == 0;
            3: return (j % 4) != 3;
            default: return (j % 4) == 0;
        endcase
    endfunction

    // Clear the filter, then drive 'ncyc' clocks of the pattern, logging each word.
    task automatic run_stream(input int kind, input int ncyc, input bit garble);
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        res_cnt = 0;
        for (int m = 0; m <= ncyc; m++) begin
            if (garble && (m % 6) != 5) mod_bit = ~pat(kind, m / 6);
            else                         mod_bit = pat(kind, m / 6);
            if (result_valid) begin
                if (res_cnt < 16) begin
                    res_at[res_cnt]  = m;
                    res_set[res_cnt] = settled;
                    res_val[res_cnt] = result;
                end
                res_cnt++;
            end
            if (m != ncyc) @(negedge clk);
        end
    endtask

    task automatic check_stream(input string req, input int nconv, input logic [23:0] expv);
        check(res_cnt == nconv, "R3 word count", res_cnt, nconv);
        for (int c = 0; c < nconv && c < 16; c++) begin
            check(res_at[c] == FRAME * (c + 1), "R3 word timing", res_at[c], FRAME * (c + 1));
            check(res_set[c] == (c >= 4), "R6 settled flag", res_set[c], (c >= 4));
            if (c >= 4) check(res_val[c] == expv, req, res_val[c], expv);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(result == 24'h0,     "R8 reset word",  result, 0);
        check(result_valid == 1'b0, "R8 reset valid", result_valid, 0);
        check(settled == 1'b0,     "R8 reset settled", settled, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_all_ones;    run_stream(0, FRAME*6, 0); check_stream("R5 clip positive end", 6, 24'h7FFFFF); endtask
    task automatic t_all_zeros;   run_stream(1, FRAME*6, 0); check_stream("R4 negative end", 6, 24'h800000); endtask
    task automatic t_balanced;    run_stream(2, FRAME*6, 0); check_stream("R1 balanced zero", 6, 24'h000000); endtask
    task automatic t_three_q;     run_stream(3, FRAME*6, 0); check_stream("R9 three-quarter density", 6, 24'h400000); endtask
    task automatic t_one_q;       run_stream(4, FRAME*6, 0); check_stream("R9 one-quarter density", 6, 24'hC00000); endtask
    task automatic t_ignored_bit; run_stream(3, FRAME*6, 1); check_stream("R2 off-strobe bit ignored", 6, 24'h400000); endtask

    task automatic t_restart_mid;
        run_stream(1, FRAME*6 + 200, 0);
        check(settled == 1'b1, "R6 settled before restart", settled, 1);
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        check(settled == 1'b0, "R7 restart drops settled", settled, 0);
        check(result_valid == 1'b0, "R7 no word on restart", result_valid, 0);
        run_stream(0, FRAME*5, 0);
        check_stream("R7 clean result after restart", 5, 24'h7FFFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_all_ones();
        t_all_zeros();
        t_balanced();
        t_three_q();
        t_one_q();
        t_ignored_bit();
        t_restart_mid();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule